// File: doc/BRIEF.md
# Branch Trace Record Logger

This block collects branch trace records from an execution pipeline and keeps them in a small on-chip trace buffer. Each record carries the linear address a control transfer left from, the linear address it arrived at, and a privilege tag naming the level the transfer ran at. Records arrive on a valid/ready handshake, at most one per clock. A privilege filter decides whether each accepted record is stored. Stored records go into the slot named by a write pointer, and the pointer then advances.

A control register sets two things. The first is the fill policy. In wrap mode the pointer cycles through the buffer and the oldest entries are overwritten. In stop mode the buffer fills once, then raises a level interrupt request and holds off further records. The second is the privilege filter. One bit drops records tagged with level 0, and a second bit drops records tagged with any other level.

Software reads stored records through a random-access read port. It clears the sticky full and interrupt flags by writing ones to a status register. It can also return the write pointer to slot 0 with a single pulse.

Top module: `btrace_logger`

## Requirements
- R1: After reset the write pointer is 0, the full flag (status bit 0) and the interrupt request (status bit 1 and `irq`) are 0, the control register reads 0, and `msg_ready` is 1.
- R2: A record accepted by the handshake and not filtered is written into the slot named by `wr_ptr`. Its from address, to address and privilege tag read back at that slot, and `wr_ptr` advances by one on the same clock edge.
- R3: While control bit 5 is set, an accepted record whose privilege tag is 0 is not written and leaves `wr_ptr` unchanged.
- R4: While control bit 6 is set, an accepted record whose privilege tag is nonzero is not written and leaves `wr_ptr` unchanged.
- R5: With control bits 5 and 6 both set, no record is written and `wr_ptr` does not move.
- R6: With control bit 4 clear, a write into slot DEPTH-1 wraps `wr_ptr` to 0, later writes overwrite the oldest slots, and neither the full flag nor the interrupt request is set.
- R7: With control bit 4 set, a write into slot DEPTH-1 sets the full flag and the interrupt request on that edge. While the full flag is set and bit 4 is set, `msg_ready` is 0 and nothing is written.
- R8: A status write with bit 0 set clears the full flag and a status write with bit 1 set clears the interrupt request. Zero bits leave their flags alone. The interrupt request stays asserted until its own bit is written.
- R9: A `ptr_clr` pulse returns `wr_ptr` to 0 and clears the full flag but not the interrupt request. A record accepted in that same cycle is discarded.
- R10: The control register keeps only bits 4, 5 and 6 of a write; every other bit reads back 0.
- R11: When a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Record offered |
| msg_ready | output | 1 | Record can be taken this cycle |
| msg_from | input | AW | Linear address the transfer left from |
| msg_to | input | AW | Linear address the transfer went to |
| msg_priv | input | PW | Privilege level of the transfer |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ctrl_q | output | 8 | Control register contents |
| sts_wr | input | 1 | Status write strobe (write one to clear) |
| sts_wdata | input | 2 | Status write data: bit 0 full, bit 1 interrupt |
| sts_q | output | 2 | Status: bit 0 full, bit 1 interrupt pending |
| ptr_clr | input | 1 | Return write pointer to slot 0 |
| wr_ptr | output | IW | Next slot to be written |
| rd_addr | input | IW | Read slot select |
| rd_from | output | AW | From address stored at rd_addr |
| rd_to | output | AW | To address stored at rd_addr |
| rd_priv | output | PW | Privilege tag stored at rd_addr |
| irq | output | 1 | Level interrupt request |

## Verification
Every state change takes effect at the clock edge that samples the handshake or the register write. So `wr_ptr`, the status bits and a newly stored slot are all due one edge after the stimulus. `msg_ready` and the read port are combinational on that state, so they are valid in the same cycle. The driver presents stimulus at a falling edge and queues the expected slot contents and pointer after the next rising edge. The monitor pops each entry at the following falling edge, steers the read port and compares the values a moment later. Status and handshake checks sample between edges in the same way.

// File: rtl/btrace_pkg.sv
package btrace_pkg;

   localparam int CTRL_W      = 8;
   localparam int CB_STOP     = 4;
   localparam int CB_DROP_SUP = 5;
   localparam int CB_DROP_USR = 6;

   localparam int STS_W       = 2;
   localparam int SB_FULL     = 0;
   localparam int SB_IRQ      = 1;

   typedef enum logic {
      FILL_WRAP = 1'b0,
      FILL_STOP = 1'b1
   } fill_mode_e;

   function automatic logic keep_record(input logic is_sup,
                                        input logic drop_sup,
                                        input logic drop_usr);
      return is_sup ? !drop_sup : !drop_usr;
   endfunction

endpackage

// File: rtl/btrace_filter.sv
module btrace_filter #(
   parameter int PW = 2
) (
   input  logic [PW-1:0] priv,
   input  logic          drop_sup,
   input  logic          drop_usr,
   output logic          keep
);
   import btrace_pkg::*;

   logic is_sup;

   always_comb begin
      is_sup = (priv == '0);
      keep   = keep_record(is_sup, drop_sup, drop_usr);
   end

endmodule

// File: rtl/btrace_wrctl.sv
module btrace_wrctl #(
   parameter int DEPTH = 8,
   parameter int IW    = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    push,
   input  logic                    clr_ptr,
   input  btrace_pkg::fill_mode_e  mode,
   input  logic                    ack_full,
   input  logic                    ack_irq,
   output logic [IW-1:0]           ptr,
   output logic                    full,
   output logic                    irq_pend,
   output logic                    ready,
   output logic                    wr_en
);
   import btrace_pkg::*;

   localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

   logic [IW-1:0] ptr_q, ptr_d;
   logic          full_q, full_d;
   logic          irq_q, irq_d;
   logic          at_last;
   logic          set_full;

   always_comb begin
      at_last  = (ptr_q == LAST);
      ready    = !(full_q && (mode == FILL_STOP));
      wr_en    = push && !clr_ptr;
      set_full = wr_en && at_last && (mode == FILL_STOP);

      ptr_d = ptr_q;
      if (clr_ptr)
         ptr_d = '0;
      else if (wr_en)
         ptr_d = at_last ? '0 : ptr_q + 1'b1;

      full_d = full_q;
      if (set_full)
         full_d = 1'b1;
      else if (clr_ptr || ack_full)
         full_d = 1'b0;

      irq_d = irq_q;
      if (set_full)
         irq_d = 1'b1;
      else if (ack_irq)
         irq_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         full_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         ptr_q  <= ptr_d;
         full_q <= full_d;
         irq_q  <= irq_d;
      end
   end

   assign ptr      = ptr_q;
   assign full     = full_q;
   assign irq_pend = irq_q;

endmodule

// File: rtl/btrace_store.sv
module btrace_store #(
   parameter int DEPTH   = 8,
   parameter int AW      = 32,
   parameter int PW      = 2,
   parameter bit RD_FLOP = 1'b0,
   parameter int IW      = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] waddr,
   input  logic [AW-1:0] w_from,
   input  logic [AW-1:0] w_to,
   input  logic [PW-1:0] w_priv,
   input  logic [IW-1:0] raddr,
   output logic [AW-1:0] r_from,
   output logic [AW-1:0] r_to,
   output logic [PW-1:0] r_priv
);
   localparam int RW = 2 * AW + PW;

   logic [RW-1:0] mem_q [DEPTH];
   logic [RW-1:0] rd_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++)
            mem_q[e] <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++)
            if (we && (waddr == IW'(e)))
               mem_q[e] <= {w_from, w_to, w_priv};
      end
   end

   always_comb begin
      rd_word = '0;
      if (int'(raddr) < DEPTH)
         rd_word = mem_q[raddr];
   end

   generate
      if (RD_FLOP) begin : g_rd_flop
         logic [RW-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               rd_q <= '0;
            else
               rd_q <= rd_word;
         end
         assign {r_from, r_to, r_priv} = rd_q;
      end else begin : g_rd_comb
         assign {r_from, r_to, r_priv} = rd_word;
      end
   endgenerate

endmodule

// File: rtl/btrace_logger.sv
module btrace_logger #(
   parameter int DEPTH   = 8,
   parameter int AW      = 32,
   parameter int PW      = 2,
   parameter bit RD_FLOP = 1'b0,
   parameter int IW      = $clog2(DEPTH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          msg_valid,
   output logic                          msg_ready,
   input  logic [AW-1:0]                 msg_from,
   input  logic [AW-1:0]                 msg_to,
   input  logic [PW-1:0]                 msg_priv,
   input  logic                          ctrl_wr,
   input  logic [btrace_pkg::CTRL_W-1:0] ctrl_wdata,
   output logic [btrace_pkg::CTRL_W-1:0] ctrl_q,
   input  logic                          sts_wr,
   input  logic [btrace_pkg::STS_W-1:0]  sts_wdata,
   output logic [btrace_pkg::STS_W-1:0]  sts_q,
   input  logic                          ptr_clr,
   output logic [IW-1:0]                 wr_ptr,
   input  logic [IW-1:0]                 rd_addr,
   output logic [AW-1:0]                 rd_from,
   output logic [AW-1:0]                 rd_to,
   output logic [PW-1:0]                 rd_priv,
   output logic                          irq
);
   import btrace_pkg::*;

   // elaboration-time parameter checks
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("btrace_logger: DEPTH must be at least 2");
      end
      if (IW < $clog2(DEPTH)) begin : g_bad_iw
         $error("btrace_logger: IW too narrow for DEPTH");
      end
      if (AW < 1 || PW < 1) begin : g_bad_width
         $error("btrace_logger: AW and PW must be positive");
      end
   endgenerate

   // control register: stop-on-full, drop level-0, drop other levels
   logic       stop_q, dsup_q, dusr_q;
   logic       unused_ctrl_bits;

   assign unused_ctrl_bits = &{1'b0, ctrl_wdata[CTRL_W-1:CB_DROP_USR+1],
                               ctrl_wdata[CB_STOP-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
         dsup_q <= 1'b0;
         dusr_q <= 1'b0;
      end else if (ctrl_wr) begin
         stop_q <= ctrl_wdata[CB_STOP];
         dsup_q <= ctrl_wdata[CB_DROP_SUP];
         dusr_q <= ctrl_wdata[CB_DROP_USR];
      end
   end

   always_comb begin
      ctrl_q              = '0;
      ctrl_q[CB_STOP]     = stop_q;
      ctrl_q[CB_DROP_SUP] = dsup_q;
      ctrl_q[CB_DROP_USR] = dusr_q;
   end

   fill_mode_e mode;
   assign mode = stop_q ? FILL_STOP : FILL_WRAP;

   logic keep;
   logic push;
   logic wr_en;
   logic full;
   logic irq_pend;

   btrace_filter #(.PW(PW)) u_filter (
      .priv     (msg_priv),
      .drop_sup (dsup_q),
      .drop_usr (dusr_q),
      .keep     (keep)
   );

   assign push = msg_valid && msg_ready && keep;

   btrace_wrctl #(.DEPTH(DEPTH), .IW(IW)) u_wrctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .clr_ptr  (ptr_clr),
      .mode     (mode),
      .ack_full (sts_wr && sts_wdata[SB_FULL]),
      .ack_irq  (sts_wr && sts_wdata[SB_IRQ]),
      .ptr      (wr_ptr),
      .full     (full),
      .irq_pend (irq_pend),
      .ready    (msg_ready),
      .wr_en    (wr_en)
   );

   btrace_store #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .RD_FLOP(RD_FLOP), .IW(IW)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wr_en),
      .waddr  (wr_ptr),
      .w_from (msg_from),
      .w_to   (msg_to),
      .w_priv (msg_priv),
      .raddr  (rd_addr),
      .r_from (rd_from),
      .r_to   (rd_to),
      .r_priv (rd_priv)
   );

   always_comb begin
      sts_q          = '0;
      sts_q[SB_FULL] = full;
      sts_q[SB_IRQ]  = irq_pend;
   end

   assign irq = irq_pend;

endmodule

// File: rtl/btrace_logger_chk.sv
module btrace_logger_chk #(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int PW    = 2,
   parameter int IW    = $clog2(DEPTH)
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          msg_valid,
   input logic                          msg_ready,
   input logic [PW-1:0]                 msg_priv,
   input logic [btrace_pkg::CTRL_W-1:0] ctrl_q,
   input logic                          sts_wr,
   input logic [btrace_pkg::STS_W-1:0]  sts_wdata,
   input logic [btrace_pkg::STS_W-1:0]  sts_q,
   input logic                          ptr_clr,
   input logic [IW-1:0]                 wr_ptr,
   input logic                          irq
);
   import btrace_pkg::*;

   localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

   logic admit;
   assign admit = msg_valid && msg_ready &&
                  ((msg_priv == '0) ? !ctrl_q[CB_DROP_SUP] : !ctrl_q[CB_DROP_USR]);

   // R2: a stored record moves the pointer on by one
   a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (admit && !ptr_clr && wr_ptr != LAST) |=> (wr_ptr == IW'($past(wr_ptr) + 1'b1)));

   // R3, R4, R5: a filtered or absent record leaves the pointer alone
   a_r5_hold_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (!admit && !ptr_clr) |=> $stable(wr_ptr));

   // R6: wrap from the last slot
   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (admit && !ptr_clr && wr_ptr == LAST) |=> (wr_ptr == '0));

   // R6: wrap mode never raises the full flag
   a_r6_no_full: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts_q[SB_FULL] && !ctrl_q[CB_STOP]) |=> !sts_q[SB_FULL]);

   // R7: a full buffer in stop mode refuses records
   a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[SB_FULL] && ctrl_q[CB_STOP]) |-> !msg_ready);

   // R8: interrupt request is sticky until its own bit is written
   a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(sts_wr && sts_wdata[SB_IRQ])) |=> irq);

   // R9: pointer clear lands on slot 0 with full dropped
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_clr |=> (wr_ptr == '0 && !sts_q[SB_FULL]));

endmodule

bind btrace_logger btrace_logger_chk #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .IW(IW)) u_chk (.*);

// File: tb/sim_btrace_logger.sv
`timescale 1ns/1ps
module sim_btrace_logger;

   localparam int D  = 8;
   localparam int AW = 32;
   localparam int PW = 2;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          msg_valid = 1'b0;
   logic          msg_ready;
   logic [AW-1:0] msg_from = '0;
   logic [AW-1:0] msg_to = '0;
   logic [PW-1:0] msg_priv = '0;
   logic          ctrl_wr = 1'b0;
   logic [7:0]    ctrl_wdata = '0;
   logic [7:0]    ctrl_q;
   logic          sts_wr = 1'b0;
   logic [1:0]    sts_wdata = '0;
   logic [1:0]    sts_q;
   logic          ptr_clr = 1'b0;
   logic [IW-1:0] wr_ptr;
   logic [IW-1:0] rd_addr = '0;
   logic [AW-1:0] rd_from;
   logic [AW-1:0] rd_to;
   logic [PW-1:0] rd_priv;
   logic          irq;

   always #4 clk = ~clk;

   btrace_logger #(.DEPTH(D), .AW(AW), .PW(PW)) u0 (.*);

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference model
   logic [IW-1:0] m_ptr = '0;
   bit m_full = 0, m_irq = 0, m_stop = 0, m_dsup = 0, m_dusr = 0;
   logic [AW-1:0] sh_f [D];
   logic [AW-1:0] sh_t [D];
   logic [PW-1:0] sh_p [D];

   typedef struct {
      logic [IW-1:0] slot;
      logic [AW-1:0] f;
      logic [AW-1:0] t;
      logic [PW-1:0] p;
      logic [IW-1:0] ptr;
      bit            chk;
      string         req;
   } item_t;

   item_t q[$];

   task automatic send(input logic [AW-1:0] f, input logic [AW-1:0] t, input logic [PW-1:0] p,
                       input string req, input bit clr = 0, input bit ack = 0);
      item_t it;
      bit rdy, keep, setf;
      @(negedge clk);
      msg_valid = 1; msg_from = f; msg_to = t; msg_priv = p;
      ptr_clr = clr; sts_wr = ack; sts_wdata = ack ? 2'b11 : 2'b00;
      rdy  = !(m_full && m_stop);
      #1 check(msg_ready == rdy, "R7", msg_ready, rdy);
      keep = (p == 0) ? !m_dsup : !m_dusr;
      setf = 0;
      it.slot = m_ptr; it.f = f; it.t = t; it.p = p; it.chk = 0; it.req = req;
      if (clr) begin
         m_ptr = '0;
      end else if (rdy && keep) begin
         it.chk = 1;
         sh_f[m_ptr] = f; sh_t[m_ptr] = t; sh_p[m_ptr] = p;
         if (m_ptr == IW'(D - 1)) begin
            setf = m_stop;
            m_ptr = '0;
         end else begin
            m_ptr = m_ptr + 1'b1;
         end
      end
      if (setf) m_full = 1; else if (clr || ack) m_full = 0;   // R11
      if (setf) m_irq = 1; else if (ack) m_irq = 0;
      it.ptr = m_ptr;
      @(posedge clk);
      #1;
      msg_valid = 0; ptr_clr = 0; sts_wr = 0; sts_wdata = 2'b00;
      q.push_back(it);
   endtask

   task automatic peek(input logic [IW-1:0] s, input string req);
      item_t it;
      it.slot = s; it.f = sh_f[s]; it.t = sh_t[s]; it.p = sh_p[s];
      it.ptr = m_ptr; it.chk = 1; it.req = req;
      q.push_back(it);
      wait (q.size() == 0);
   endtask

   task automatic wr_ctrl(input logic [7:0] v);
      @(negedge clk);
      ctrl_wr = 1; ctrl_wdata = v;
      @(posedge clk);
      #1 ctrl_wr = 0;
      m_stop = v[4]; m_dsup = v[5]; m_dusr = v[6];
   endtask

   task automatic wr_sts(input logic [1:0] v);
      @(negedge clk);
      sts_wr = 1; sts_wdata = v;
      @(posedge clk);
      #1 sts_wr = 0; sts_wdata = 2'b00;
      if (v[0]) m_full = 0;
      if (v[1]) m_irq = 0;
   endtask

   task automatic do_clr();
      @(negedge clk);
      ptr_clr = 1;
      @(posedge clk);
      #1 ptr_clr = 0;
      m_ptr = '0; m_full = 0;
   endtask

   task automatic chk_flags(input string req);
      wait (q.size() == 0);
      @(negedge clk);
      #2;
      check(sts_q == {m_irq, m_full}, req, sts_q, {m_irq, m_full});
      check(irq == m_irq, req, irq, m_irq);
      check(wr_ptr == m_ptr, req, wr_ptr, m_ptr);
   endtask

   // monitor: compares queued expectations one edge after the write
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            rd_addr = it.slot;
            #1;
            check(wr_ptr == it.ptr, it.req, wr_ptr, it.ptr);
            if (it.chk) begin
               check(rd_from == it.f, it.req, rd_from, it.f);
               check(rd_to == it.t, it.req, rd_to, it.t);
               check(rd_priv == it.p, it.req, rd_priv, it.p);
            end
         end
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hang expected=done");
      summary();
   end

   initial begin
      for (int i = 0; i < D; i++) begin sh_f[i] = '0; sh_t[i] = '0; sh_p[i] = '0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1: reset state
      check(wr_ptr == 0, "R1", wr_ptr, 0);
      check(sts_q == 0, "R1", sts_q, 0);
      check(irq == 0, "R1", irq, 0);
      check(ctrl_q == 0, "R1", ctrl_q, 0);
      check(msg_ready == 1, "R1", msg_ready, 1);

      // R2: plain stores
      send(32'h1000_0010, 32'h2000_0000, 2'd0, "R2");
      send(32'h1000_0024, 32'h3000_0040, 2'd3, "R2");
      send(32'h1000_0038, 32'h0000_4000, 2'd1, "R2");

      // R10 then R3: only bits 4..6 kept, 0xAF keeps bit 5
      wr_ctrl(8'hAF);
      @(negedge clk);
      check(ctrl_q == 8'h20, "R10", ctrl_q, 8'h20);
      send(32'hDEAD_0000, 32'hBEEF_0000, 2'd0, "R3");
      send(32'h5555_0000, 32'h6666_0000, 2'd2, "R3");

      // R4: drop nonzero levels
      wr_ctrl(8'h40);
      send(32'h7777_0000, 32'h8888_0000, 2'd0, "R4");
      send(32'h9999_0000, 32'hAAAA_0000, 2'd3, "R4");

      // R5: drop all
      wr_ctrl(8'h60);
      send(32'hBBBB_0000, 32'hCCCC_0000, 2'd0, "R5");
      send(32'hDDDD_0000, 32'hEEEE_0000, 2'd1, "R5");

      // R6: wrap mode, pointer at 5; five more wrap to 2 overwriting 0 and 1
      wr_ctrl(8'h00);
      for (int i = 0; i < 5; i++)
         send(32'h4000_0000 + 32'(i), 32'h5000_0000 + 32'(i), PW'(i), "R6");
      chk_flags("R6");

      // R9: clear with a record offered in the same cycle
      send(32'hF00D_0000, 32'hFACE_0000, 2'd1, "R9", 1'b1, 1'b0);
      peek(3'd2, "R9");
      chk_flags("R9");

      // R7: stop mode fill
      wr_ctrl(8'h10);
      for (int i = 0; i < D; i++)
         send(32'h6000_0000 + 32'(i), 32'h7000_0000 + 32'(i), PW'(i), "R7");
      chk_flags("R7");
      send(32'h0BAD_0000, 32'h0BAD_1111, 2'd0, "R7");
      peek(3'd0, "R7");
      chk_flags("R7");

      // R8: write-one-to-clear
      wr_sts(2'b00);
      chk_flags("R8");
      wr_sts(2'b01);
      chk_flags("R8");
      @(negedge clk);
      check(msg_ready == 1, "R8", msg_ready, 1);
      wr_sts(2'b10);
      chk_flags("R8");

      // R11: fill again, last write coincides with a clear of both flags
      for (int i = 0; i < D - 1; i++)
         send(32'h8000_0000 + 32'(i), 32'h9000_0000 + 32'(i), 2'd2, "R11");
      send(32'h8000_00FF, 32'h9000_00FF, 2'd3, "R11", 1'b0, 1'b1);
      chk_flags("R11");

      // R9: pointer clear drops full but keeps the interrupt
      do_clr();
      chk_flags("R9");
      send(32'hC0DE_0000, 32'hC0DE_0001, 2'd1, "R9");
      chk_flags("R9");

      wait (q.size() == 0);
      repeat (2) @(negedge clk);
      summary();
   end

endmodule